// File: doc/BRIEF.md
# PLL Configuration Register Bank

This block is the software-facing configuration store for a clock-generator phase-locked loop. It sits on a simple synchronous byte bus and occupies six consecutive offsets. Behind them it holds the control byte, the bandwidth/status byte, a 12-bit loop multiplier split across two bytes, the VCO range value and the reference divider. Its outputs drive the PLL's analog and divider logic directly: multiplier, range, divider, prescaler, VCO power range, PLL enable, base clock select and interrupt enable.

Several bits are interlocked. The programming registers (multiplier, range, divider) are frozen while the PLL runs. The base clock can only be moved onto the PLL when the PLL is on and a non-zero range is programmed, and once it is there the PLL cannot be turned off. In automatic bandwidth mode the block watches the lock status input and raises a flag and an interrupt on every lock transition. In manual mode the flag, the lock view and the interrupt enable are held at zero, and the acquisition bit becomes a plain software bit.

Top module: `pllcfg_regbank`

## Requirements
- R1: Offsets 0..5 decode, in order, control, bandwidth, multiplier high, multiplier low, VCO range and reference divider; after reset they read 0x20, 0x00, 0x00, 0x40, 0x40 and 0x01, so the PLL enable output is 1 and the multiplier output is 0x040.
- R2: The control byte is laid out as bit 7 interrupt enable, bit 6 lock flag, bit 5 PLL enable, bit 4 base clock select, bits 3:2 prescaler and bits 1:0 VCO power range; the prescaler and power range fields are always writable and drive their outputs.
- R3: Unimplemented bits read 0: bits 4:0 of the bandwidth byte (bit 0 is reserved and ignores writes), bits 7:4 of multiplier high, bits 7:4 of the divider byte, and every offset above 5.
- R4: While the bandwidth byte's bit 7 (automatic mode) is 0, the interrupt enable is 0 and writes to it are ignored; clearing automatic mode also clears it.
- R5: While base clock select is 1, PLL enable stays 1 and a control write carrying 0 in bit 5 leaves it at 1.
- R6: In manual mode, the lock flag (control bit 6) and the lock view (bandwidth bit 6) read 0, and the acquisition bit (bandwidth bit 5) is a writable register. In automatic mode bit 6 shows the lock input, and bit 5 shows the acquisition input and ignores writes.
- R7: Base clock select reads 0 and ignores a written 1 unless PLL enable was 1 before the write, stays 1 after it, and the VCO range value is non-zero.
- R8: While PLL enable is 1, writes to the multiplier, VCO range and divider bytes are ignored; while it is 0 they take the written value.
- R9: In automatic mode every change of the lock input sets the lock flag on the next clock edge. A read of offset 0 clears the flag after the read returns it. The interrupt output is 1 while flag and interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (3) | Byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (used for flag clearing) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pll_lock_i | input | 1 | Lock status from the PLL |
| pll_acq_i | input | 1 | Acquisition status from the PLL |
| cfg_mul | output | MUL_W (12) | Loop multiplier |
| cfg_vrange | output | VRS_W (8) | VCO range value |
| cfg_refdiv | output | RDS_W (4) | Reference divider |
| cfg_prescale | output | 2 | Prescaler select |
| cfg_vpwr | output | 2 | VCO power range |
| cfg_pll_en | output | 1 | PLL enable |
| cfg_base_sel | output | 1 | Base clock taken from the PLL |
| cfg_irq_en | output | 1 | Interrupt enable |
| cfg_auto | output | 1 | Automatic bandwidth mode |
| cfg_acq | output | 1 | Effective acquisition mode bit |
| pll_irq | output | 1 | Lock-change interrupt |

## Verification
The assertions watch, on every cycle, the invariants the interlocks must keep: base clock select never stands without PLL enable and a non-zero range, a selected base clock holds the PLL on through the next edge, the programming outputs never move while the PLL is on, the interrupt enable never stands without automatic mode, and the flag only rises in automatic mode. The bench scenarios show the things an invariant cannot: the reset values of each offset, which write patterns are ignored, masked and zero-read bits, the acquisition bit switching between software and input, and the exact cycles in which the flag sets on a lock edge and clears after a control read.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

   localparam int OFS_CTL  = 0;
   localparam int OFS_BW   = 1;
   localparam int OFS_MULH = 2;
   localparam int OFS_MULL = 3;
   localparam int OFS_VRS  = 4;
   localparam int OFS_RDS  = 5;

   localparam int N_PROG   = 4;   // programming bytes at OFS_MULH..OFS_RDS
   localparam int PROG_HI  = 0;
   localparam int PROG_LO  = 1;
   localparam int PROG_VRS = 2;
   localparam int PROG_RDS = 3;

   // control byte bit positions (software decodes these)
   localparam int CTL_IE   = 7;
   localparam int CTL_FLAG = 6;
   localparam int CTL_ON   = 5;
   localparam int CTL_BCS  = 4;

   // bandwidth byte bit positions
   localparam int BW_AUTO  = 7;
   localparam int BW_LOCK  = 6;
   localparam int BW_ACQ   = 5;

   function automatic logic [7:0] low_mask(input int w);
      return 8'((16'd1 << w) - 16'd1);
   endfunction

endpackage

// File: rtl/pllcfg_byte_reg.sv
module pllcfg_byte_reg #(
   parameter logic [7:0] MASK = 8'hFF,
   parameter logic [7:0] RST  = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] d,
   output logic [7:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)   q <= RST & MASK;
      else if (we)  q <= d & MASK;
   end

endmodule

// File: rtl/pllcfg_ctrl.sv
module pllcfg_ctrl
   import pllcfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_ctl,
   input  logic       wr_bw,
   input  logic       rd_ctl,
   input  logic [7:0] wdata,
   input  logic       vrs_nz,
   input  logic       lock_i,
   input  logic       acq_i,
   output logic       ie_q,
   output logic       flag_q,
   output logic       pllon_q,
   output logic       bcs_q,
   output logic [1:0] pre_q,
   output logic [1:0] vpr_q,
   output logic       auto_q,
   output logic       acq_eff,
   output logic [7:0] ctl_rd,
   output logic [7:0] bw_rd
);

   logic acq_sw_q;
   logic lock_prev_q;
   logic leave_auto;
   logic pllon_d;
   logic lock_edge;

   assign leave_auto = !auto_q || (wr_bw && !wdata[BW_AUTO]);
   assign pllon_d    = wdata[CTL_ON] | bcs_q;
   assign lock_edge  = lock_i ^ lock_prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q        <= 1'b0;
         flag_q      <= 1'b0;
         pllon_q     <= 1'b1;
         bcs_q       <= 1'b0;
         pre_q       <= 2'b00;
         vpr_q       <= 2'b00;
         auto_q      <= 1'b0;
         acq_sw_q    <= 1'b0;
         lock_prev_q <= 1'b0;
      end else begin
         lock_prev_q <= lock_i;

         if (wr_ctl) begin
            pre_q   <= wdata[3:2];
            vpr_q   <= wdata[1:0];
            pllon_q <= pllon_d;
            bcs_q   <= wdata[CTL_BCS] & pllon_q & pllon_d & vrs_nz;
         end else if (!vrs_nz || !pllon_q) begin
            bcs_q   <= 1'b0;
         end

         if (wr_bw) begin
            auto_q <= wdata[BW_AUTO];
            if (!auto_q) acq_sw_q <= wdata[BW_ACQ];
         end

         if (leave_auto)   ie_q <= 1'b0;
         else if (wr_ctl)  ie_q <= wdata[CTL_IE];

         if (leave_auto)      flag_q <= 1'b0;
         else if (lock_edge)  flag_q <= 1'b1;
         else if (rd_ctl)     flag_q <= 1'b0;
      end
   end

   assign acq_eff = auto_q ? acq_i : acq_sw_q;
   assign ctl_rd  = {ie_q, flag_q, pllon_q, bcs_q, pre_q, vpr_q};
   assign bw_rd   = {auto_q, auto_q & lock_i, acq_eff, 5'b00000};

endmodule

// File: rtl/pllcfg_rdmux.sv
module pllcfg_rdmux
   import pllcfg_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic [ADDR_W-1:0]       addr,
   input  logic [7:0]              ctl_rd,
   input  logic [7:0]              bw_rd,
   input  logic [N_PROG-1:0][7:0]  prog,
   output logic [7:0]              rdata
);

   always_comb begin
      case (int'(addr))
         OFS_CTL:  rdata = ctl_rd;
         OFS_BW:   rdata = bw_rd;
         OFS_MULH: rdata = prog[PROG_HI];
         OFS_MULL: rdata = prog[PROG_LO];
         OFS_VRS:  rdata = prog[PROG_VRS];
         OFS_RDS:  rdata = prog[PROG_RDS];
         default:  rdata = 8'h00;
      endcase
   end

endmodule

// File: rtl/pllcfg_regbank.sv
module pllcfg_regbank
   import pllcfg_pkg::*;
#(
   parameter int               ADDR_W  = 3,
   parameter int               MUL_W   = 12,
   parameter int               VRS_W   = 8,
   parameter int               RDS_W   = 4,
   parameter logic [MUL_W-1:0] MUL_RST = MUL_W'(12'h040),
   parameter logic [VRS_W-1:0] VRS_RST = VRS_W'(8'h40),
   parameter logic [RDS_W-1:0] RDS_RST = RDS_W'(4'h1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              pll_lock_i,
   input  logic              pll_acq_i,
   output logic [MUL_W-1:0]  cfg_mul,
   output logic [VRS_W-1:0]  cfg_vrange,
   output logic [RDS_W-1:0]  cfg_refdiv,
   output logic [1:0]        cfg_prescale,
   output logic [1:0]        cfg_vpwr,
   output logic              cfg_pll_en,
   output logic              cfg_base_sel,
   output logic              cfg_irq_en,
   output logic              cfg_auto,
   output logic              cfg_acq,
   output logic              pll_irq
);

   localparam int         HI_W     = MUL_W - 8;
   localparam logic [7:0] MASK_HI  = low_mask(HI_W);
   localparam logic [7:0] MASK_LO  = 8'hFF;
   localparam logic [7:0] MASK_VRS = low_mask(VRS_W);
   localparam logic [7:0] MASK_RDS = low_mask(RDS_W);
   localparam logic [7:0] RST_HI   = 8'(MUL_RST >> 8);
   localparam logic [7:0] RST_LO   = MUL_RST[7:0];
   localparam logic [7:0] RST_VRS  = 8'(VRS_RST);
   localparam logic [7:0] RST_RDS  = 8'(RDS_RST);
   localparam logic [N_PROG-1:0][7:0] PROG_MASK = {MASK_RDS, MASK_VRS, MASK_LO, MASK_HI};
   localparam logic [N_PROG-1:0][7:0] PROG_RST  = {RST_RDS, RST_VRS, RST_LO, RST_HI};

   if (ADDR_W < 3) begin : g_bad_addr
      $error("pllcfg_regbank: ADDR_W must cover six offsets");
   end
   if (MUL_W < 9 || MUL_W > 16) begin : g_bad_mul
      $error("pllcfg_regbank: MUL_W must be 9..16");
   end
   if (VRS_W < 1 || VRS_W > 8) begin : g_bad_vrs
      $error("pllcfg_regbank: VRS_W must be 1..8");
   end
   if (RDS_W < 1 || RDS_W > 8) begin : g_bad_rds
      $error("pllcfg_regbank: RDS_W must be 1..8");
   end

   logic [N_PROG-1:0][7:0] prog_q;
   logic [7:0]             ctl_rd;
   logic [7:0]             bw_rd;
   logic                   wr_ctl;
   logic                   wr_bw;
   logic                   rd_ctl;
   logic                   vrs_nz;
   logic                   pll_flag;

   assign wr_ctl = bus_wr && (int'(bus_addr) == OFS_CTL);
   assign wr_bw  = bus_wr && (int'(bus_addr) == OFS_BW);
   assign rd_ctl = bus_rd && (int'(bus_addr) == OFS_CTL);

   // R8: programming bytes are writable only while the PLL is off
   for (genvar i = 0; i < N_PROG; i++) begin : g_prog
      logic we;
      assign we = bus_wr && !cfg_pll_en && (int'(bus_addr) == OFS_MULH + i);
      pllcfg_byte_reg #(
         .MASK (PROG_MASK[i]),
         .RST  (PROG_RST[i])
      ) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (we),
         .d     (bus_wdata),
         .q     (prog_q[i])
      );
   end

   assign cfg_mul    = {prog_q[PROG_HI][HI_W-1:0], prog_q[PROG_LO]};
   assign cfg_vrange = prog_q[PROG_VRS][VRS_W-1:0];
   assign cfg_refdiv = prog_q[PROG_RDS][RDS_W-1:0];
   assign vrs_nz     = |cfg_vrange;

   pllcfg_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctl  (wr_ctl),
      .wr_bw   (wr_bw),
      .rd_ctl  (rd_ctl),
      .wdata   (bus_wdata),
      .vrs_nz  (vrs_nz),
      .lock_i  (pll_lock_i),
      .acq_i   (pll_acq_i),
      .ie_q    (cfg_irq_en),
      .flag_q  (pll_flag),
      .pllon_q (cfg_pll_en),
      .bcs_q   (cfg_base_sel),
      .pre_q   (cfg_prescale),
      .vpr_q   (cfg_vpwr),
      .auto_q  (cfg_auto),
      .acq_eff (cfg_acq),
      .ctl_rd  (ctl_rd),
      .bw_rd   (bw_rd)
   );

   pllcfg_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
      .addr   (bus_addr),
      .ctl_rd (ctl_rd),
      .bw_rd  (bw_rd),
      .prog   (prog_q),
      .rdata  (bus_rdata)
   );

   assign pll_irq = pll_flag & cfg_irq_en;

endmodule

// File: rtl/pllcfg_regbank_chk.sv
module pllcfg_regbank_chk #(
   parameter int MUL_W = 12,
   parameter int VRS_W = 8,
   parameter int RDS_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [MUL_W-1:0] cfg_mul,
   input logic [VRS_W-1:0] cfg_vrange,
   input logic [RDS_W-1:0] cfg_refdiv,
   input logic             cfg_pll_en,
   input logic             cfg_base_sel,
   input logic             cfg_irq_en,
   input logic             cfg_auto,
   input logic             flag
);

   a_r4_irq_en_needs_auto: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_auto |-> !cfg_irq_en);

   a_r7_base_sel_needs_pll_and_range: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_base_sel |-> (cfg_pll_en && (cfg_vrange != '0)));

   a_r5_base_sel_keeps_pll: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_base_sel |=> cfg_pll_en);

   a_r8_prog_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_pll_en |=> ($stable(cfg_mul) && $stable(cfg_vrange) && $stable(cfg_refdiv)));

   a_r9_flag_only_in_auto: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> cfg_auto);

endmodule

bind pllcfg_regbank pllcfg_regbank_chk #(
   .MUL_W (MUL_W),
   .VRS_W (VRS_W),
   .RDS_W (RDS_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_mul      (cfg_mul),
   .cfg_vrange   (cfg_vrange),
   .cfg_refdiv   (cfg_refdiv),
   .cfg_pll_en   (cfg_pll_en),
   .cfg_base_sel (cfg_base_sel),
   .cfg_irq_en   (cfg_irq_en),
   .cfg_auto     (cfg_auto),
   .flag         (pll_flag)
);

// File: tb/pllcfg_regbank_tb.sv
`timescale 1ns/1ps
module pllcfg_regbank_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  bus_addr;
   logic        bus_wr;
   logic        bus_rd;
   logic [7:0]  bus_wdata;
   logic [7:0]  bus_rdata;
   logic        pll_lock_i;
   logic        pll_acq_i;
   logic [11:0] cfg_mul;
   logic [7:0]  cfg_vrange;
   logic [3:0]  cfg_refdiv;
   logic [1:0]  cfg_prescale;
   logic [1:0]  cfg_vpwr;
   logic        cfg_pll_en;
   logic        cfg_base_sel;
   logic        cfg_irq_en;
   logic        cfg_auto;
   logic        cfg_acq;
   logic        pll_irq;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   pllcfg_regbank u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr     (bus_addr),
      .bus_wr       (bus_wr),
      .bus_rd       (bus_rd),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .pll_lock_i   (pll_lock_i),
      .pll_acq_i    (pll_acq_i),
      .cfg_mul      (cfg_mul),
      .cfg_vrange   (cfg_vrange),
      .cfg_refdiv   (cfg_refdiv),
      .cfg_prescale (cfg_prescale),
      .cfg_vpwr     (cfg_vpwr),
      .cfg_pll_en   (cfg_pll_en),
      .cfg_base_sel (cfg_base_sel),
      .cfg_irq_en   (cfg_irq_en),
      .cfg_auto     (cfg_auto),
      .cfg_acq      (cfg_acq),
      .pll_irq      (pll_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      bus_rd   = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd   = 1'b0;
   endtask

   task automatic read_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
      logic [7:0] v;
      bus_read(a, v);
      chk(req, {24'd0, v}, {24'd0, exp});
   endtask

   task automatic t_reset;
      read_chk("R1 ctl reset",  3'd0, 8'h20);
      read_chk("R1 bw reset",   3'd1, 8'h00);
      read_chk("R1 mulh reset", 3'd2, 8'h00);
      read_chk("R1 mull reset", 3'd3, 8'h40);
      read_chk("R1 vrs reset",  3'd4, 8'h40);
      read_chk("R1 rds reset",  3'd5, 8'h01);
      read_chk("R3 offset 6",   3'd6, 8'h00);
      read_chk("R3 offset 7",   3'd7, 8'h00);
      chk("R1 pll_en reset", {31'd0, cfg_pll_en}, 32'd1);
      chk("R1 mul reset",    {20'd0, cfg_mul}, 32'h040);
   endtask

   task automatic t_prog_protect;
      bus_write(3'd3, 8'h55);
      read_chk("R8 mull frozen", 3'd3, 8'h40);
      bus_write(3'd4, 8'h00);
      read_chk("R8 vrs frozen", 3'd4, 8'h40);
      bus_write(3'd0, 8'h00);
      chk("R2 pll_en off", {31'd0, cfg_pll_en}, 32'd0);
      bus_write(3'd2, 8'hFA);
      read_chk("R3 mulh upper nibble", 3'd2, 8'h0A);
      bus_write(3'd3, 8'h23);
      chk("R8 mul written", {20'd0, cfg_mul}, 32'hA23);
      bus_write(3'd5, 8'hF7);
      read_chk("R3 rds upper nibble", 3'd5, 8'h07);
      chk("R8 refdiv written", {28'd0, cfg_refdiv}, 32'h7);
      bus_write(3'd4, 8'h00);
      read_chk("R8 vrs written", 3'd4, 8'h00);
   endtask

   task automatic t_base_select;
      bus_write(3'd0, 8'h30);
      read_chk("R7 bcs blocked, pll was off", 3'd0, 8'h20);
      bus_write(3'd0, 8'h30);
      read_chk("R7 bcs blocked, range zero", 3'd0, 8'h20);
      bus_write(3'd0, 8'h00);
      bus_write(3'd4, 8'h80);
      bus_write(3'd0, 8'h20);
      bus_write(3'd0, 8'h30);
      read_chk("R7 bcs accepted", 3'd0, 8'h30);
      chk("R7 base_sel out", {31'd0, cfg_base_sel}, 32'd1);
      bus_write(3'd4, 8'h11);
      read_chk("R8 vrs frozen under bcs", 3'd4, 8'h80);
      bus_write(3'd0, 8'h0B);
      read_chk("R5 pll held on", 3'd0, 8'h2B);
      chk("R5 pll_en out", {31'd0, cfg_pll_en}, 32'd1);
      chk("R2 prescale out", {30'd0, cfg_prescale}, 32'd2);
      chk("R2 vpwr out", {30'd0, cfg_vpwr}, 32'd3);
   endtask

   task automatic t_manual_mode;
      bus_write(3'd0, 8'hAB);
      read_chk("R4 ie ignored in manual", 3'd0, 8'h2B);
      chk("R4 irq_en out", {31'd0, cfg_irq_en}, 32'd0);
      bus_write(3'd1, 8'h20);
      read_chk("R6 acq writable in manual", 3'd1, 8'h20);
      chk("R6 acq out", {31'd0, cfg_acq}, 32'd1);
      @(negedge clk);
      pll_lock_i = 1'b1;
      repeat (2) @(negedge clk);
      read_chk("R6 flag reads 0 in manual", 3'd0, 8'h2B);
      read_chk("R6 lock reads 0 in manual", 3'd1, 8'h20);
      chk("R6 no irq in manual", {31'd0, pll_irq}, 32'd0);
      bus_write(3'd1, 8'h01);
      read_chk("R3 reserved bit, R6 acq cleared", 3'd1, 8'h00);
   endtask

   task automatic t_auto_mode;
      bus_write(3'd1, 8'h80);
      read_chk("R6 lock visible in auto", 3'd1, 8'hC0);
      bus_write(3'd1, 8'hA0);
      read_chk("R6 acq write ignored in auto", 3'd1, 8'hC0);
      @(negedge clk);
      pll_acq_i = 1'b1;
      read_chk("R6 acq follows input", 3'd1, 8'hE0);
      bus_write(3'd0, 8'hA0);
      read_chk("R4 ie set in auto", 3'd0, 8'hA0);
      chk("R9 no irq before edge", {31'd0, pll_irq}, 32'd0);
      @(negedge clk);
      pll_lock_i = 1'b0;
      @(negedge clk);
      chk("R9 irq after lock edge", {31'd0, pll_irq}, 32'd1);
      read_chk("R9 flag read", 3'd0, 8'hE0);
      chk("R9 irq cleared by read", {31'd0, pll_irq}, 32'd0);
      read_chk("R9 flag clear", 3'd0, 8'hA0);
      @(negedge clk);
      pll_lock_i = 1'b1;
      @(negedge clk);
      chk("R9 irq on rising lock", {31'd0, pll_irq}, 32'd1);
      bus_write(3'd1, 8'h00);
      chk("R4 irq_en cleared leaving auto", {31'd0, cfg_irq_en}, 32'd0);
      chk("R9 irq cleared leaving auto", {31'd0, pll_irq}, 32'd0);
      read_chk("R4 ctl after leaving auto", 3'd0, 8'h20);
      read_chk("R6 bw after leaving auto", 3'd1, 8'h00);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n      = 1'b0;
      bus_addr   = '0;
      bus_wr     = 1'b0;
      bus_rd     = 1'b0;
      bus_wdata  = '0;
      pll_lock_i = 1'b0;
      pll_acq_i  = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_prog_protect();
      t_base_select();
      t_manual_mode();
      t_auto_mode();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule